// File: doc/BRIEF.md
# Reprogrammable Integer Clock Divider

This block divides an incoming clock by a whole number between 1 and 32. The result is a divided clock whose high and low phases are equal, including for odd ratios. A 5-bit ratio code selects the ratio. The block samples that code on every rising edge of the input clock.

A new ratio never takes effect on the fly. When the code changes, the divider keeps producing the old waveform for a bounded time. It then parks its output low for a fixed idle interval and starts again cleanly with the new ratio. The same idle-and-restart sequence runs when the synchronous active-low reset is released. This gives downstream logic a predictable quiet gap around every ratio switch, and it never sees a shortened pulse.

Top module: `ratio_clock_divider`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk_in`, `clk_out` is held low.
- R2: The ratio N is the plain binary value of `ratio_code`, where bit 4 is the most significant bit, and the code 00000 selects N = 32.
- R3: While running with ratio N, `clk_out` repeats a pattern of N input half-periods high followed by N half-periods low, for odd and even N. For N = 1, `clk_out` equals `clk_in`.
- R4: Count the first rising edge with `rst_n` high as edge 1. After reset release, `clk_out` stays low until edge 192 and rises at edge 192. The first high phase has full length.
- R5: Let C be the first rising edge that samples a new code. The old waveform continues unchanged through edge C+64, with no phase disturbance. The output restarts no earlier than edge C+257 and no later than edge C+320, which places idle entry between 65 and 128 edges after C.
- R6: Before a restart after a code change, `clk_out` is low for 192 input periods. It then rises at a rising edge and continues with the new ratio, starting with a full high phase.
- R7: While the code is held constant, the output waveform runs without interruption.
- R8: If the code changes again before the restart, the block restarts with the code present at the restart edge. It does not restart with the first new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided; all logic runs on it |
| rst_n | input | 1 | Synchronous active-low reset; release starts the restart sequence |
| ratio_code | input | 5 | Binary ratio select; 00000 means divide by 32 |
| clk_out | output | 1 | Divided clock with equal high and low phases |

## Verification
A wrong counter or half-width value shows up at `clk_out` within one output period after a restart, as a high or low phase of the wrong length. A wrong idle counter or boundary arming moves the restart edge out of its fixed position after reset, or out of its allowed window after a code change. Such a fault is visible as soon as the restart occurs, at most 320 input periods after the change. A stale latched ratio shows up as the wrong period right after restart. A sequencer that reacts to the code too early cuts the old waveform short inside its guaranteed 64-period tail.

// File: rtl/rcd_pkg.sv
`timescale 1ns/1ps
// Shared types for the ratio clock divider.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package rcd_pkg;

    // Phases of the ratio-switch sequence.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,   // output parked low, counting the quiet gap
        SEQ_RUN  = 2'd1,   // divided clock active, code watched
        SEQ_WAIT = 2'd2    // change seen, still running until slot boundary
    } seq_state_e;

endpackage

// File: rtl/rcd_sequencer.sv
`timescale 1ns/1ps
// Ratio-switch sequencer. Registers the ratio code, detects a change against
// the active code, lets the old waveform run to the second slot boundary of a
// free-running counter, then holds a fixed idle gap before restarting.
// Assumes: SLOT is a power of two; IDLE_CYC >= 2.
module rcd_sequencer
    import rcd_pkg::*;
#(
    parameter int CODE_W   = 5,
    parameter int SLOT     = 64,
    parameter int IDLE_CYC = 192,
    localparam int RW      = CODE_W + 1,
    localparam int SW      = $clog2(SLOT),
    localparam int IW      = $clog2(IDLE_CYC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    output logic              run,
    output logic              run_nx,
    output logic              start,
    output logic [RW-1:0]     ratio
);

    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_act;
    logic [CODE_W-1:0] code_sel;
    seq_state_e        st;
    seq_state_e        st_nx;
    logic [SW-1:0]     slot_cnt;
    logic              slot_end;
    logic              armed;
    logic [IW-1:0]     idle_cnt;
    logic              idle_last;

    assign slot_end  = (slot_cnt == SW'(SLOT - 1));
    assign idle_last = (idle_cnt == IW'(IDLE_CYC - 1));

    // Sample the ratio code once per input clock.
    always_ff @(posedge clk) begin
        code_q <= code_in;
    end

    // Free-running slot counter that sets the idle-entry boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_cnt <= '0;
        else        slot_cnt <= slot_cnt + SW'(1);
    end

    // Next-state decision for the switch sequence.
    always_comb begin
        st_nx = st;
        case (st)
            SEQ_RUN:  if (code_q != code_act)  st_nx = SEQ_WAIT;
            SEQ_WAIT: if (slot_end && armed)   st_nx = SEQ_IDLE;
            SEQ_IDLE: if (idle_last)           st_nx = SEQ_RUN;
            default:                           st_nx = SEQ_IDLE;
        endcase
    end

    // State, boundary arming, idle gap counting and active code capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SEQ_IDLE;
            armed    <= 1'b0;
            idle_cnt <= '0;
            code_act <= '0;
        end else begin
            st <= st_nx;
            case (st)
                SEQ_RUN:  armed <= slot_end;
                SEQ_WAIT: if (slot_end) armed <= 1'b1;
                SEQ_IDLE: idle_cnt <= idle_last ? '0 : idle_cnt + IW'(1);
                default:  armed <= 1'b0;
            endcase
            if (st == SEQ_IDLE && idle_last) code_act <= code_q;
        end
    end

    // Decode: the all-zero code stands for the largest ratio.
    assign code_sel = (st == SEQ_IDLE) ? code_q : code_act;
    assign ratio    = (code_sel == '0) ? RW'(1 << CODE_W) : {1'b0, code_sel};
    assign run      = (st == SEQ_RUN) || (st == SEQ_WAIT);
    assign run_nx   = (st_nx == SEQ_RUN) || (st_nx == SEQ_WAIT);
    assign start    = (st == SEQ_IDLE) && idle_last;

    // ---- checks ----
    logic [SW+1:0] wait_seen;
    logic [IW:0]   idle_seen;

    // Count consecutive cycles spent waiting and idling, independent of the FSM counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_seen <= '0;
            idle_seen <= '0;
        end else begin
            wait_seen <= (st == SEQ_WAIT) ? wait_seen + (SW+2)'(1) : '0;
            idle_seen <= (st == SEQ_IDLE) ? idle_seen + (IW+1)'(1) : '0;
        end
    end

    // R5: waiting never outlasts two slots.
    p_wait_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SEQ_WAIT) |-> (wait_seen < (SW+2)'(2 * SLOT)));

    // R6: every restart follows exactly the idle gap.
    p_idle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (idle_seen == (IW+1)'(IDLE_CYC)));

    // R2: the ratio in use cannot move while running.
    p_ratio_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(ratio));

endmodule

// File: rtl/rcd_core.sv
`timescale 1ns/1ps
// Division core. A modulo-N counter forms a rising-edge pulse of N/2 (even)
// or (N-1)/2 (odd) cycles; for odd N a half-cycle delayed copy taken on the
// falling edge is ORed in to stretch the high phase to exactly N/2 periods.
// Assumes: ratio is stable while run is high; ratio 1 is handled by the top.
module rcd_core #(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          run_nx,
    input  logic          start,
    input  logic [RW-1:0] ratio,
    output logic          div_out
);

    logic [RW-1:0] cnt;
    logic [RW-1:0] cnt_nx;
    logic [RW-1:0] half;
    logic          pos_q;
    logic          neg_q;

    assign half   = ratio >> 1;
    assign cnt_nx = (start || cnt == ratio - RW'(1)) ? '0 : cnt + RW'(1);

    // Period counter and rising-edge pulse; restart forces a full high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            pos_q <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            pos_q <= run_nx && (cnt_nx < half);
        end
    end

    // Half-cycle delayed copy of the pulse for odd-ratio stretching.
    always_ff @(negedge clk) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= pos_q;
    end

    assign div_out = run & (ratio[0] ? (pos_q | neg_q) : pos_q);

    // R3: the counter stays inside the period while running.
    p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < ratio));

    // R4 / R6: a restart begins with the high phase.
    p_restart_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ratio > RW'(1)) |=> pos_q);

endmodule

// File: rtl/ratio_clock_divider.sv
`timescale 1ns/1ps
// Top of the reprogrammable integer clock divider: sequencer plus division
// core; ratio 1 bypasses the core and gates the input clock directly.
// Assumes: ratio_code is synchronous to clk_in or tolerates one-cycle skew.
module ratio_clock_divider #(
    parameter int CODE_W   = 5,
    parameter int SLOT     = 64,
    parameter int IDLE_CYC = 192,
    localparam int RW      = CODE_W + 1
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] ratio_code,
    output logic              clk_out
);

    logic          run;
    logic          run_nx;
    logic          start;
    logic [RW-1:0] ratio;
    logic          div_out;

    rcd_sequencer #(
        .CODE_W   (CODE_W),
        .SLOT     (SLOT),
        .IDLE_CYC (IDLE_CYC)
    ) u_seq (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .code_in (ratio_code),
        .run     (run),
        .run_nx  (run_nx),
        .start   (start),
        .ratio   (ratio)
    );

    rcd_core #(
        .RW (RW)
    ) u_core (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .run     (run),
        .run_nx  (run_nx),
        .start   (start),
        .ratio   (ratio),
        .div_out (div_out)
    );

    assign clk_out = (ratio == RW'(1)) ? (clk_in & run) : div_out;

    // R1: nothing leaves the block in the cycle after a reset edge.
    p_quiet_after_reset_r1: assert property (@(posedge clk_in)
        !rst_n |=> !run);

endmodule

// File: tb/tb_ratio_clock_divider.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected waveform windows; the monitor
// samples clk_out every half period and compares each window once it is complete.
module tb_ratio_clock_divider;

    typedef struct {
        int    base;   // edge where the expected pattern starts high
        int    n;      // ratio of the pattern
        int    lo;     // first half-period sample checked
        int    hi;     // last half-period sample checked
        string req;
    } item_t;

    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [4:0] ratio_code = 5'd5;
    logic       clk_out;

    bit    trace [0:32767];
    int    ecnt   = 0;
    int    checks = 0;
    int    fails  = 0;
    bit    busy   = 1'b0;
    int    cur_r  = 0;
    int    cur_n  = 0;
    item_t exp_q [$];

    ratio_clock_divider dut (
        .clk_in     (clk_in),
        .rst_n      (rst_n),
        .ratio_code (ratio_code),
        .clk_out    (clk_out)
    );

    always #2 clk_in = ~clk_in;

    // Monitor sampling: even index after rising edge, odd index after falling edge.
    always @(posedge clk_in) begin
        automatic int e = ecnt;
        ecnt = ecnt + 1;
        #1 trace[2*e] = clk_out;
    end
    always @(negedge clk_in) begin
        #1 trace[2*(ecnt-1)+1] = clk_out;
    end

    function automatic int ratio_of(input logic [4:0] c);
        return (c == 5'd0) ? 32 : int'(c);   // R2 decoding
    endfunction

    function automatic bit expect_at(input int h, input item_t it);
        if (h < 2*it.base) return 1'b0;
        return ((h - 2*it.base) % (2*it.n)) < it.n;
    endfunction

    // Scoreboard monitor: pop a window, wait until it is sampled, compare.
    initial begin
        item_t it;
        forever begin
            while (exp_q.size() == 0) @(posedge clk_in);
            busy = 1'b1;
            it = exp_q.pop_front();
            while (ecnt*2 <= it.hi + 4) @(posedge clk_in);
            begin
                int bad = -1;
                for (int h = it.lo; h <= it.hi; h++)
                    if (bad < 0 && trace[h] != expect_at(h, it)) bad = h;
                checks++;
                if (bad >= 0) begin
                    fails++;
                    $display("FAIL %s sample %0d ratio %0d: got %0b expected %0b",
                             it.req, bad, it.n, trace[bad], expect_at(bad, it));
                end
            end
            busy = 1'b0;
        end
    end

    task automatic push(input int base, input int n, input int lo, input int hi, input string req);
        item_t it;
        it.base = base; it.n = n; it.lo = lo; it.hi = hi; it.req = req;
        exp_q.push_back(it);
    endtask

    // Driver: change the code (optionally twice), check the old tail, find and check restart.
    task automatic change_code(input logic [4:0] first, input logic [4:0] last,
                               input bit twice, input string req);
        int c;
        int r;
        bit found;
        while (ecnt <= cur_r + 6*cur_n + 6) @(negedge clk_in);
        @(negedge clk_in);
        c = ecnt;
        ratio_code = first;
        // R5: old waveform untouched through edge C+64
        push(cur_r, cur_n, 2*c, 2*(c+64)+1, "R5 old tail");
        if (twice) begin
            repeat (12) @(negedge clk_in);
            ratio_code = last;
        end
        while (ecnt <= c + 325) @(negedge clk_in);
        found = 1'b0;
        r = 0;
        for (int e = c + 257; e <= c + 320; e++) begin
            if (!found && trace[2*e]) begin
                bit quiet = 1'b1;
                for (int h = 2*(e-192); h < 2*e; h++) if (trace[h]) quiet = 1'b0;
                if (quiet) begin found = 1'b1; r = e; end
            end
        end
        checks++;
        if (!found) begin
            fails++;
            $display("FAIL R5 R6 restart window: got none in edges %0d..%0d expected one", c+257, c+320);
        end else begin
            cur_r = r;
            cur_n = ratio_of(last);
            // R6 quiet gap plus new ratio from a full high phase; req names the pattern rule
            push(cur_r, cur_n, 2*(cur_r-192), 2*cur_r + 12*cur_n - 1, req);
        end
    endtask

    // Main driver sequence.
    initial begin
        int rel;
        repeat (10) @(negedge clk_in);
        push(1000000, 1, 4, 19, "R1 reset low");
        @(negedge clk_in);
        rel = ecnt;
        rst_n = 1'b1;
        cur_r = rel + 191;
        cur_n = 5;
        push(cur_r, cur_n, 2*rel, 2*cur_r + 12*cur_n - 1, "R4 power-up restart");
        push(cur_r, cur_n, 2*cur_r, 2*cur_r + 80*cur_n - 1, "R7 stable code");
        cur_n = 5;
        while (ecnt <= cur_r + 40*cur_n + 6) @(negedge clk_in);
        change_code(5'd0,  5'd0,  1'b0, "R2 code zero is 32");
        change_code(5'd1,  5'd1,  1'b0, "R3 ratio one passthrough");
        change_code(5'd2,  5'd2,  1'b0, "R3 ratio two");
        change_code(5'd7,  5'd7,  1'b0, "R3 odd ratio seven");
        change_code(5'd31, 5'd31, 1'b0, "R2 R3 ratio 31");
        change_code(5'd3,  5'd6,  1'b1, "R8 second change wins");
        change_code(5'd16, 5'd16, 1'b0, "R2 R3 msb code 16");
        while (ecnt <= cur_r + 6*cur_n + 8) @(negedge clk_in);
        while (exp_q.size() != 0 || busy) @(negedge clk_in);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule